// File: doc/BRIEF.md
# Flash Write Completion Status Poller

This block runs on the host side of a parallel flash bus. After the host logic has issued the final write cycle of a program or erase command, it pulses `start`. The poller then performs repeated status read cycles on the flash bus until the internal flash operation is over. Each read drives a read strobe for a fixed number of clocks, and a programmable idle gap separates consecutive reads. The block then reports the result with a one-cycle `done` or `error` pulse.

Two detection methods are available, selected per operation. The first is data polling: while busy, the flash returns the complement of the written value on the polling bit. The second is toggle detection: while busy, bit 6 flips on every read. The end of the internal operation is not synchronised to the host, so a read taken at that moment may look finished when the flash is not. For this reason the block only accepts completion that two consecutive reads confirm. A per-operation timeout, counted in clock cycles, covers operations that range from microseconds (byte program) to tens of milliseconds (whole-array erase).

Top module: `flash_status_poller`

## Requirements
- R1: While `rst_n` is low, and in every cycle after reset until the first `start`, `rd_strobe`, `done` and `error` are all low.
- R2: A start accepted at clock edge E0 begins the first read in the next cycle. Every read holds `rd_strobe` high for exactly RD_LEN consecutive cycles, and `rd_data` is sampled in the last of them.
- R3: Between two reads of one operation, `rd_strobe` stays low for max(`gap_cycles`, 1) cycles, so reads repeat with period RD_LEN + max(`gap_cycles`, 1).
- R4: With `mode_toggle` = 0 (data polling), completion is reached when two consecutive reads both equal the expected byte in all 8 bits. The expected byte is FFh when `erase_sel` = 1 and `expect_data` otherwise.
- R5: In data polling mode, one read that equals the expected byte does not complete the operation when the next read differs from it.
- R6: With `mode_toggle` = 1, completion is reached when bit 6 of a read equals bit 6 of the previous read of the same operation. The first read of an operation never completes it on its own.
- R7: If completion has not been reached within `timeout_limit` active cycles (the cycle after the start edge counts as active cycle 1), `error` pulses in the next cycle and polling stops. If the confirming read is sampled in that same last cycle, `done` is reported instead.
- R8: `done` and `error` are single-cycle pulses and are never high together. In their cycle and afterwards, `rd_strobe` stays low until the next start.
- R9: A `start` pulse while an operation is running is ignored. The mode, expected byte, timeout and gap are captured at the accepted start, and later changes to these inputs have no effect on the running operation.
- R10: `done` is high in the cycle directly after the sampling cycle of the confirming read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse after the final command write cycle |
| mode_toggle | input | 1 | 0 = data polling, 1 = toggle detection |
| erase_sel | input | 1 | 1 = operation is an erase (expected byte FFh) |
| expect_data | input | DATA_W | Byte written by a program operation |
| timeout_limit | input | TMO_W | Timeout in clock cycles |
| gap_cycles | input | GAP_W | Idle cycles between reads (0 acts as 1) |
| rd_data | input | DATA_W | Flash data bus during reads |
| rd_strobe | output | 1 | Flash read strobe (chip and output enable, active high) |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle timeout pulse |

## Verification
The hardest case to create from the ports is a read that coincides with completion. This covers a single read that already shows the final value while the neighbouring reads still show busy. It also covers a toggle-mode busy read whose bit 6 happens to equal the final bit 6. The bench models the flash, which switches to final data at a chosen cycle and can return the final byte for a single read index while it is still busy. It then sweeps the switch cycle, that read index and the gap length, so that these coincidences fall on every read phase. The bench also places the timeout on the exact sampling cycle of the confirming read, and on the cycle before it, to test the priority of `done` over `error`.

// File: rtl/poll_pkg.sv
package poll_pkg;

   // Sequencer states of the status poller
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_READ = 2'd1,
      PS_GAP  = 2'd2
   } poll_state_e;

   // Value expected on the data bus after an erase
   function automatic logic [63:0] erased_word();
      return {64{1'b1}};
   endfunction

endpackage

// File: rtl/poll_read_seq.sv
module poll_read_seq
   import poll_pkg::*;
#(
   parameter int RD_LEN = 2,
   parameter int GAP_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             halt,
   input  logic [GAP_W-1:0] gap_len,
   output logic             rd_strobe,
   output logic             smp_vld,
   output logic             active
);

   poll_state_e      state_q, state_d;
   logic [GAP_W-1:0] gap_cnt_q;
   logic [GAP_W-1:0] gap_eff;
   logic             last_beat;

   assign gap_eff = (gap_len == '0) ? GAP_W'(1) : gap_len;

   // Beat counter inside a read cycle: the variant depends on RD_LEN
   generate
      if (RD_LEN == 1) begin : g_single_beat
         assign last_beat = 1'b1;
      end else begin : g_multi_beat
         localparam int RC_W = $clog2(RD_LEN);
         logic [RC_W-1:0] beat_q;

         assign last_beat = (beat_q == RC_W'(RD_LEN - 1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               beat_q <= '0;
            end else if (state_q == PS_READ && !last_beat && !halt) begin
               beat_q <= beat_q + RC_W'(1);
            end else begin
               beat_q <= '0;
            end
         end
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_IDLE: begin
            if (launch) state_d = PS_READ;
         end
         PS_READ: begin
            if (halt)           state_d = PS_IDLE;
            else if (last_beat) state_d = PS_GAP;
         end
         PS_GAP: begin
            if (halt)                      state_d = PS_IDLE;
            else if (gap_cnt_q == gap_eff) state_d = PS_READ;
         end
         default: state_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= PS_IDLE;
         gap_cnt_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q != PS_GAP) begin
            gap_cnt_q <= GAP_W'(1);
         end else if (gap_cnt_q != gap_eff) begin
            gap_cnt_q <= gap_cnt_q + GAP_W'(1);
         end
      end
   end

   assign rd_strobe = (state_q == PS_READ);
   assign smp_vld   = (state_q == PS_READ) && last_beat;
   assign active    = (state_q != PS_IDLE);

endmodule

// File: rtl/poll_judge.sv
module poll_judge #(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6,
   parameter bit FULL_CMP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              mode_tgl,
   input  logic [DATA_W-1:0] exp_byte,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_data,
   output logic              match
);

   logic [DATA_W-1:0] prev_q;
   logic              have_prev_q;
   logic              data_ok;
   logic              tgl_ok;

   // Data polling comparison: whole byte or polling bit only
   generate
      if (FULL_CMP) begin : g_full_cmp
         assign data_ok = (smp_data == exp_byte) && (prev_q == exp_byte);
      end else begin : g_bit_cmp
         assign data_ok = (smp_data[POLL_BIT] == exp_byte[POLL_BIT]) &&
                          (prev_q[POLL_BIT]   == exp_byte[POLL_BIT]);
      end
   endgenerate

   assign tgl_ok = (smp_data[TOGGLE_BIT] == prev_q[TOGGLE_BIT]);

   assign match = smp_vld && have_prev_q && (mode_tgl ? tgl_ok : data_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q      <= '0;
         have_prev_q <= 1'b0;
      end else if (clear) begin
         have_prev_q <= 1'b0;
      end else if (smp_vld) begin
         prev_q      <= smp_data;
         have_prev_q <= 1'b1;
      end
   end

endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
   parameter int TMO_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);

   localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W:0]   elapsed;

   // Cycles of activity including the current one
   assign elapsed = {1'b0, cnt_q} + (TMO_W + 1)'(1);
   assign expire  = run && (elapsed >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (launch) begin
         cnt_q <= '0;
      end else if (run && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + TMO_W'(1);
      end
   end

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
   import poll_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6,
   parameter bit FULL_CMP   = 1'b1,
   parameter int RD_LEN     = 2,
   parameter int GAP_W      = 4,
   parameter int TMO_W      = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_toggle,
   input  logic              erase_sel,
   input  logic [DATA_W-1:0] expect_data,
   input  logic [TMO_W-1:0]  timeout_limit,
   input  logic [GAP_W-1:0]  gap_cycles,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_strobe,
   output logic              done,
   output logic              error
);

   localparam logic [DATA_W-1:0] ERASED = erased_word()[DATA_W-1:0];

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 8 || DATA_W > 64) begin : g_bad_width
         $error("flash_status_poller: DATA_W must lie in 8..64");
      end
      if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W || POLL_BIT == TOGGLE_BIT) begin : g_bad_bits
         $error("flash_status_poller: status bit positions invalid");
      end
      if (RD_LEN < 1) begin : g_bad_rdlen
         $error("flash_status_poller: RD_LEN must be at least 1");
      end
      if (GAP_W < 1 || TMO_W < 2) begin : g_bad_cnt
         $error("flash_status_poller: counter widths too small");
      end
   endgenerate

   logic              active;
   logic              launch;
   logic              halt;
   logic              smp_vld;
   logic              match;
   logic              expire;
   logic              mode_q;
   logic [DATA_W-1:0] exp_q;
   logic [TMO_W-1:0]  lim_q;
   logic [GAP_W-1:0]  gap_q;
   logic              done_q;
   logic              err_q;

   assign launch = start && !active;
   assign halt   = match || expire;

   // Operation settings captured at an accepted start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         exp_q  <= '0;
         lim_q  <= '0;
         gap_q  <= '0;
      end else if (launch) begin
         mode_q <= mode_toggle;
         exp_q  <= erase_sel ? ERASED : expect_data;
         lim_q  <= timeout_limit;
         gap_q  <= gap_cycles;
      end
   end

   poll_read_seq #(
      .RD_LEN (RD_LEN),
      .GAP_W  (GAP_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .halt      (halt),
      .gap_len   (gap_q),
      .rd_strobe (rd_strobe),
      .smp_vld   (smp_vld),
      .active    (active)
   );

   poll_judge #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT),
      .FULL_CMP   (FULL_CMP)
   ) u_judge (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (launch),
      .mode_tgl (mode_q),
      .exp_byte (exp_q),
      .smp_vld  (smp_vld),
      .smp_data (rd_data),
      .match    (match)
   );

   poll_timer #(
      .TMO_W (TMO_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .run    (active),
      .limit  (lim_q),
      .expire (expire)
   );

   // Result pulses: completion wins over a coincident timeout
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= match;
         err_q  <= expire && !match;
      end
   end

   assign done  = done_q;
   assign error = err_q;

endmodule

// File: rtl/poll_chk.sv
module poll_chk #(
   parameter int RD_LEN = 2,
   parameter int GAP_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [GAP_W-1:0] gap_cycles,
   input logic             rd_strobe,
   input logic             done,
   input logic             error
);

   localparam int RUN_W = $clog2(RD_LEN + 2) + 1;

   logic             act_q;
   logic             first_q;
   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] gap_eff;
   logic [GAP_W:0]   low_run_q;
   logic [RUN_W-1:0] hi_run_q;
   logic             launch_seen;

   assign launch_seen = start && (!act_q || done || error);
   assign gap_eff     = (gap_q == '0) ? GAP_W'(1) : gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         first_q   <= 1'b0;
         gap_q     <= '0;
         low_run_q <= '0;
         hi_run_q  <= '0;
      end else begin
         if (launch_seen) begin
            act_q   <= 1'b1;
            first_q <= 1'b1;
            gap_q   <= gap_cycles;
         end else begin
            if (done || error) act_q <= 1'b0;
            if (rd_strobe)     first_q <= 1'b0;
         end
         if (rd_strobe)                  low_run_q <= '0;
         else if (low_run_q != '1)       low_run_q <= low_run_q + 1'b1;
         if (!rd_strobe)                 hi_run_q <= '0;
         else if (hi_run_q != '1)        hi_run_q <= hi_run_q + 1'b1;
      end
   end

   // R8
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error);

   // R8
   idle_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> !rd_strobe);

   // R2
   strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_strobe && hi_run_q != '0 && !$past(done || error) && !done && !error)
         |-> (hi_run_q == RUN_W'(RD_LEN)));

   // R3
   gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_strobe) && !first_q) |-> (low_run_q == {1'b0, gap_eff}));

   // R7
   result_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> act_q);

endmodule

bind flash_status_poller poll_chk #(
   .RD_LEN (RD_LEN),
   .GAP_W  (GAP_W)
) u_poll_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .gap_cycles (gap_cycles),
   .rd_strobe  (rd_strobe),
   .done       (done),
   .error      (error)
);

// File: tb/tb_flash_status_poller.sv
module tb_flash_status_poller;

   localparam int RD_LEN = 2;
   localparam int GAP_W  = 4;
   localparam int TMO_W  = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             mode_toggle = 1'b0;
   logic             erase_sel = 1'b0;
   logic [7:0]       expect_data = 8'h00;
   logic [TMO_W-1:0] timeout_limit = '0;
   logic [GAP_W-1:0] gap_cycles = '0;
   logic [7:0]       rd_data;
   logic             rd_strobe;
   logic             done;
   logic             error;

   int checks = 0;
   int failures = 0;
   int wd = 0;

   // Flash model state
   int         cyc_m = 0;
   int         rd_idx = 0;
   int         srun = 0;
   int         b_m = 1000000;
   int         sp_m = -1;
   logic       mode_m = 1'b0;
   logic [7:0] fin_m = 8'h00;
   logic [7:0] expb_m = 8'h00;
   logic       arm = 1'b0;

   always #10 clk = ~clk;

   flash_status_poller #(
      .DATA_W (8),
      .RD_LEN (RD_LEN),
      .GAP_W  (GAP_W),
      .TMO_W  (TMO_W)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .mode_toggle   (mode_toggle),
      .erase_sel     (erase_sel),
      .expect_data   (expect_data),
      .timeout_limit (timeout_limit),
      .gap_cycles    (gap_cycles),
      .rd_data       (rd_data),
      .rd_strobe     (rd_strobe),
      .done          (done),
      .error         (error)
   );

   function automatic logic [7:0] busyv(logic md, int k, logic [7:0] e);
      if (md) return {1'b0, k[0], 6'h2B};
      return {~e[7], e[6:0] ^ 7'h11 ^ 7'(k)};
   endfunction

   assign rd_data = (cyc_m >= b_m || rd_idx == sp_m) ? fin_m : busyv(mode_m, rd_idx, expb_m);

   always @(posedge clk) begin
      if (start && arm) begin
         cyc_m  <= 1;
         rd_idx <= 0;
         srun   <= 0;
      end else begin
         cyc_m <= cyc_m + 1;
         if (rd_strobe) begin
            if (srun == RD_LEN - 1) begin
               rd_idx <= rd_idx + 1;
               srun   <= 0;
            end else begin
               srun <= srun + 1;
            end
         end
      end
   end

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 190000) begin
         failures = failures + 1;
         $display("FAIL watchdog expired act=%0d exp=%0d", wd, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
      end
   endtask

   task automatic run_case(input logic md, input logic er, input logic [7:0] ex,
                           input int gp, input int b, input int sp, input int lim,
                           input int ig, input string tag);
      int         p;
      logic [7:0] expb;
      logic [7:0] fin;
      logic [7:0] pv;
      logic [7:0] v;
      bit         exp_done;
      int         endc;
      int         exp_hi;
      int         exp_rise;
      int         hi;
      int         rise;
      int         got;
      bit         got_done;
      bit         got_err;
      bit         both;
      bit         prev_s;
      p        = RD_LEN + ((gp == 0) ? 1 : gp);
      expb     = er ? 8'hFF : ex;
      fin      = md ? 8'h5C : expb;
      exp_done = 1'b0;
      endc     = lim;
      pv       = 8'h00;
      for (int k = 0; k < 100000; k++) begin
         int s;
         s = RD_LEN + k * p;
         if (s > lim) begin
            endc = lim;
            break;
         end
         v = (s >= b || k == sp) ? fin : busyv(md, k, expb);
         if (k >= 1 && (md ? (v[6] == pv[6]) : (v == expb && pv == expb))) begin
            exp_done = 1'b1;
            endc     = s;
            break;
         end
         pv = v;
      end
      exp_hi   = 0;
      exp_rise = 0;
      for (int c = 1; c <= endc; c++) begin
         if (((c - 1) % p) < RD_LEN) exp_hi = exp_hi + 1;
         if (((c - 1) % p) == 0)     exp_rise = exp_rise + 1;
      end

      @(negedge clk);
      mode_toggle   = md;
      erase_sel     = er;
      expect_data   = ex;
      gap_cycles    = GAP_W'(gp);
      timeout_limit = TMO_W'(lim);
      mode_m        = md;
      expb_m        = expb;
      fin_m         = fin;
      b_m           = b;
      sp_m          = sp;
      arm           = 1'b1;
      start         = 1'b1;
      @(negedge clk);
      start = 1'b0;
      arm   = 1'b0;
      hi = 0; rise = 0; got = -1; got_done = 0; got_err = 0; both = 0; prev_s = 0;
      for (int n = 1; n <= lim + 6; n++) begin
         if (rd_strobe) begin
            hi = hi + 1;
            if (!prev_s) rise = rise + 1;
         end
         prev_s = rd_strobe;
         if (done || error) begin
            got      = n;
            got_done = done;
            got_err  = error;
            both     = done && error;
            break;
         end
         if (ig != 0 && n == ig) begin
            start       = 1'b1;
            expect_data = ~ex;
            mode_toggle = ~md;
            erase_sel   = ~er;
            gap_cycles  = GAP_W'(gp + 2);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(exp_done ? (got_done && !got_err) : (got_err && !got_done),
          exp_done ? tag : "R7", {30'd0, got_err, got_done}, exp_done ? 1 : 2);
      chk(got == endc + 1, exp_done ? "R10" : "R7", got, endc + 1);
      chk(hi == exp_hi, "R2", hi, exp_hi);
      chk(rise == exp_rise, "R3", rise, exp_rise);
      chk(!both, "R8", int'(both), 0);
      for (int q = 0; q < 3; q++) begin
         @(negedge clk);
         chk(!rd_strobe && !done && !error, "R8",
             {29'd0, rd_strobe, done, error}, 0);
      end
   endtask

   initial begin
      int gaps[3];
      int bs[4];
      int sps[3];
      int lims[5];
      gaps = '{0, 1, 3};
      bs   = '{1, 4, 11, 27};
      sps  = '{-1, 1, 3};
      lims = '{1, 2, 3, 7, 20};

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!rd_strobe && !done && !error, "R1", {29'd0, rd_strobe, done, error}, 0);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(!rd_strobe && !done && !error, "R1", {29'd0, rd_strobe, done, error}, 0);
      end

      // R4 R5 R6: completion sweep
      for (int md = 0; md < 2; md++) begin
         for (int er = 0; er < ((md == 1) ? 1 : 2); er++) begin
            for (int gi = 0; gi < 3; gi++) begin
               for (int bi = 0; bi < 4; bi++) begin
                  for (int si = 0; si < 3; si++) begin
                     string tg;
                     tg = (md == 1) ? "R6" : ((sps[si] >= 0) ? "R5" : "R4");
                     run_case(md[0], er[0], 8'h3C ^ 8'(gaps[gi] * 16 + bs[bi]),
                              gaps[gi], bs[bi], sps[si], 200, 0, tg);
                  end
               end
            end
         end
      end

      // R7: timeouts with a flash that never finishes
      for (int md = 0; md < 2; md++) begin
         for (int g = 0; g < 3; g += 2) begin
            for (int li = 0; li < 5; li++) begin
               run_case(md[0], 1'b0, 8'hA5, g, 1000000, -1, lims[li], 0, "R7");
            end
         end
      end

      // R7: confirming read on the last allowed cycle, and one cycle late
      run_case(1'b0, 1'b0, 8'h96, 0, 1, -1, 5, 0, "R7");
      run_case(1'b0, 1'b0, 8'h96, 0, 1, -1, 4, 0, "R7");
      run_case(1'b1, 1'b0, 8'h00, 2, 1, -1, 6, 0, "R7");

      // R9: start and input changes during an operation are ignored
      run_case(1'b0, 1'b0, 8'h71, 1, 11, -1, 200, 3, "R9");
      run_case(1'b1, 1'b0, 8'h00, 0, 9, -1, 200, 2, "R9");
      run_case(1'b0, 1'b1, 8'h12, 3, 20, 1, 200, 4, "R9");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule